// File: doc/BRIEF.md
# Packet Buffer Page Admission Controller

This block decides whether requests for space in a shared packet buffer can be granted. It keeps one count of free pages, where a page is 256 bytes times a size multiplier (the multiplier is 1 here, so the buffer holds 24 pages, or 6144 bytes). Each cycle it can take one allocation request and one release. An allocation request is marked as transmit or receive and carries a page count. A release returns a page count to the pool.

The host can program a transmit reservation. While that value is non-zero, receive traffic is refused once free space falls to the reservation or below it. Transmit traffic can still use every free page. The reservation is a margin on top of the memory already in use. It does not follow transmit allocations, so software must rewrite it if it wants the transmit share to stay fixed.

A soft memory-manager reset returns every page to the pool and leaves the reservation as it was. A hard reset clears the reservation as well.

Top module: `pkt_buf_admit`

## Requirements
- R1: After hard reset, `free_pages` and `total_pages` both read 0x18, the reservation reads 0, and `grant` and `deny` are low.
- R2: `cfg_word` bits 7:0 hold the reservation, which `cfg_wr` writes from `cfg_wdata`. Bits 11:9 hold the size-multiplier code 3'b001 (M=1). All other bits read 0, and no write can change bits 15:8.
- R3: For each cycle with `alloc_req` high, exactly one of `grant` and `deny` is high on the next cycle. In a cycle after no request, both are low.
- R4: A request whose page count exceeds the current free count is denied and leaves `free_pages` unchanged.
- R5: A granted request lowers `free_pages` by its page count. The new value is visible in the same cycle that `grant` is high.
- R6: With a reservation of 0, receive requests are granted under the same rule as transmit requests, down to zero free pages.
- R7: With a non-zero reservation, a receive request is denied whenever free pages are less than or equal to the reservation. A transmit request under the same conditions is still granted if it fits.
- R8: Transmit allocations and releases never change the programmed reservation.
- R9: A release adds its page count to `free_pages`, and the result saturates at the total size.
- R10: When a release and an allocation fall in the same cycle, the grant decision uses the free count from before that cycle, and both changes are applied together.
- R11: `mmu_reset` reloads `free_pages` with the total size on the next cycle and keeps the reservation. An allocation in the same cycle is denied, and a release in that cycle is ignored.
- R12: `total_pages` always reads 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, synchronous |
| mmu_reset | input | 1 | Soft reset of the memory manager |
| alloc_req | input | 1 | Allocation request strobe |
| alloc_is_rx | input | 1 | 1 = receive request, 0 = transmit request |
| alloc_pages | input | 8 | Pages requested |
| rel_req | input | 1 | Release strobe |
| rel_pages | input | 8 | Pages released |
| cfg_wr | input | 1 | Write strobe for the reservation |
| cfg_wdata | input | 8 | New reservation, in pages |
| grant | output | 1 | Previous request granted |
| deny | output | 1 | Previous request denied |
| free_pages | output | 8 | Free page count |
| total_pages | output | 8 | Total page count |
| cfg_word | output | 16 | Multiplier code and reservation |

## Verification
Allocation and release can arrive in the same cycle. The bench drives both strobes together in three cases:
- a request that fits only if the release is counted first, which must be denied;
- a plain combined update;
- a large release alongside a grant, which must clip at the total size.

For each case the expected `grant`, `deny` and free count are computed in the bench from the free count before that cycle. A soft reset that lands together with both a request and a release is also checked. It must deny the request, drop the release and keep the reservation.

// File: rtl/pkt_buf_admit.sv
module pkt_buf_admit #(
  parameter int       W           = 8,
  parameter int       TOTAL_PAGES = 24,
  parameter bit [2:0] MULT_CODE   = 3'd1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mmu_reset,
  input  logic         alloc_req,
  input  logic         alloc_is_rx,
  input  logic [W-1:0] alloc_pages,
  input  logic         rel_req,
  input  logic [W-1:0] rel_pages,
  input  logic         cfg_wr,
  input  logic [7:0]   cfg_wdata,
  output logic         grant,
  output logic         deny,
  output logic [W-1:0] free_pages,
  output logic [W-1:0] total_pages,
  output logic [15:0]  cfg_word
);
  localparam logic [W-1:0] TOTAL   = W'(TOTAL_PAGES);
  localparam logic [W:0]   TOTAL_X = {1'b0, TOTAL};

  logic [W-1:0] free_q;
  logic [7:0]   resv_q;
  logic         fits, rx_block, ok;
  logic [W:0]   take, give, sum;
  logic [W-1:0] free_d;

  assign fits     = alloc_pages <= free_q;
  assign rx_block = alloc_is_rx && (resv_q != 8'd0) && ({1'b0, free_q} <= {1'b0, W'(resv_q)});
  assign ok       = alloc_req && !mmu_reset && fits && !rx_block;

  assign take   = ok      ? {1'b0, alloc_pages} : '0;
  assign give   = rel_req ? {1'b0, rel_pages}   : '0;
  assign sum    = {1'b0, free_q} - take + give;
  assign free_d = (sum > TOTAL_X) ? TOTAL : sum[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= TOTAL;
      resv_q <= 8'd0;
      grant  <= 1'b0;
      deny   <= 1'b0;
    end else begin
      grant  <= ok;
      deny   <= alloc_req && !ok;
      free_q <= mmu_reset ? TOTAL : free_d;
      if (cfg_wr) resv_q <= cfg_wdata;
    end
  end

  assign free_pages  = free_q;
  assign total_pages = TOTAL;
  assign cfg_word    = {4'b0000, MULT_CODE, 1'b0, resv_q};
endmodule

module pkt_buf_admit_chk #(
  parameter int W           = 8,
  parameter int TOTAL_PAGES = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mmu_reset,
  input logic         alloc_req,
  input logic         alloc_is_rx,
  input logic [W-1:0] alloc_pages,
  input logic         rel_req,
  input logic         cfg_wr,
  input logic         grant,
  input logic         deny,
  input logic [W-1:0] free_pages,
  input logic [15:0]  cfg_word
);
  localparam logic [W-1:0] TOTAL = W'(TOTAL_PAGES);

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> (grant ^ deny)); // R3
  AST_NO_STRAY_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> (!grant && !deny)); // R3
  AST_FREE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    free_pages <= TOTAL); // R9
  AST_RX_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_is_rx && cfg_word[7:0] != 8'd0 && {1'b0, free_pages} <= {1'b0, W'(cfg_word[7:0])})
    |=> deny); // R7
  AST_OVERSIZE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_pages > free_pages && !rel_req && !mmu_reset)
    |=> (deny && $stable(free_pages))); // R4
  AST_RESV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_word)); // R8
  AST_MMU_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_reset |=> (free_pages == TOTAL && !grant)); // R11
endmodule

bind pkt_buf_admit pkt_buf_admit_chk #(.W(W), .TOTAL_PAGES(TOTAL_PAGES)) i_chk (
  .clk(clk), .rst_n(rst_n), .mmu_reset(mmu_reset), .alloc_req(alloc_req),
  .alloc_is_rx(alloc_is_rx), .alloc_pages(alloc_pages), .rel_req(rel_req),
  .cfg_wr(cfg_wr), .grant(grant), .deny(deny), .free_pages(free_pages),
  .cfg_word(cfg_word)
);

// File: tb/test_pkt_buf_admit.sv
`timescale 1ns/1ps
module test_pkt_buf_admit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mmu_reset = 1'b0, alloc_req = 1'b0, alloc_is_rx = 1'b0, rel_req = 1'b0, cfg_wr = 1'b0;
  logic [7:0] alloc_pages = '0, rel_pages = '0, cfg_wdata = '0;
  logic grant, deny;
  logic [7:0] free_pages, total_pages;
  logic [15:0] cfg_word;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pkt_buf_admit i_pkt_buf_admit (
    .clk(clk), .rst_n(rst_n), .mmu_reset(mmu_reset), .alloc_req(alloc_req),
    .alloc_is_rx(alloc_is_rx), .alloc_pages(alloc_pages), .rel_req(rel_req),
    .rel_pages(rel_pages), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .grant(grant), .deny(deny), .free_pages(free_pages),
    .total_pages(total_pages), .cfg_word(cfg_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit a, input bit rx, input int ap,
                      input bit r, input int rp,
                      input bit w, input int wd, input bit m);
    alloc_req = a; alloc_is_rx = rx; alloc_pages = 8'(ap);
    rel_req = r; rel_pages = 8'(rp);
    cfg_wr = w; cfg_wdata = 8'(wd); mmu_reset = m;
    @(negedge clk);
    alloc_req = 0; alloc_is_rx = 0; alloc_pages = 0;
    rel_req = 0; rel_pages = 0; cfg_wr = 0; cfg_wdata = 0; mmu_reset = 0;
  endtask

  task automatic expect_resp(input string req, input bit g, input int fr);
    chk({req, " grant"}, grant, g);
    chk({req, " deny"}, deny, !g);
    chk({req, " free"}, free_pages, fr);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 free", free_pages, 8'h18);
    chk("R1 grant", grant, 0);
    chk("R1 deny", deny, 0);
    chk("R1 resv", cfg_word[7:0], 0);
    chk("R2 word", cfg_word, 16'h0200);
    chk("R12 total", total_pages, 8'h18);
  endtask

  task automatic t_tx_basic();
    step(1, 0, 5, 0, 0, 0, 0, 0);
    expect_resp("R5", 1, 19);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 idle grant", grant, 0);
    chk("R3 idle deny", deny, 0);
    step(1, 0, 20, 0, 0, 0, 0, 0);
    expect_resp("R4", 0, 19);
    step(1, 1, 19, 0, 0, 0, 0, 0);
    expect_resp("R6", 1, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    expect_resp("R6 zero", 1, 0);
    step(0, 0, 0, 1, 30, 0, 0, 0);
    chk("R9 saturate", free_pages, 24);
    chk("R12 total", total_pages, 8'h18);
  endtask

  task automatic t_reserve();
    step(0, 0, 0, 0, 0, 1, 10, 0);
    chk("R2 word", cfg_word, 16'h020A);
    step(1, 1, 14, 0, 0, 0, 0, 0);
    expect_resp("R7 above", 1, 10);
    step(1, 1, 1, 0, 0, 0, 0, 0);
    expect_resp("R7 equal", 0, 10);
    step(1, 0, 4, 0, 0, 0, 0, 0);
    expect_resp("R7 tx", 1, 6);
    chk("R8 resv", cfg_word[7:0], 10);
    step(1, 1, 1, 0, 0, 0, 0, 0);
    expect_resp("R7 below", 0, 6);
    step(0, 0, 0, 1, 5, 0, 0, 0);
    chk("R9 add", free_pages, 11);
    chk("R8 resv", cfg_word[7:0], 10);
    step(1, 1, 1, 0, 0, 0, 0, 0);
    expect_resp("R7 just above", 1, 10);
  endtask

  task automatic t_concurrent();
    step(1, 0, 12, 1, 5, 0, 0, 0);
    expect_resp("R10 old count", 0, 15);
    step(1, 0, 3, 1, 2, 0, 0, 0);
    expect_resp("R10 both", 1, 14);
    step(1, 0, 4, 1, 24, 0, 0, 0);
    expect_resp("R10 clip", 1, 24);
  endtask

  task automatic t_mmu();
    step(1, 0, 8, 0, 0, 0, 0, 0);
    expect_resp("R5", 1, 16);
    step(1, 0, 1, 1, 3, 0, 0, 1);
    expect_resp("R11", 0, 24);
    chk("R11 resv", cfg_word[7:0], 10);
    step(1, 0, 2, 0, 0, 0, 0, 1);
    expect_resp("R11 full", 0, 24);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1 resv", cfg_word, 16'h0200);
    chk("R1 grant", grant, 0);
  endtask

  initial begin
    t_reset();
    t_tx_basic();
    t_reserve();
    t_concurrent();
    t_mmu();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule